// File: doc/BRIEF.md
# NAND Page ECC Syndrome Checker and Corrector

This block takes the 3-byte ECC read back with a 256-byte data block and the 3-byte ECC freshly computed over the same data. It sorts the difference into one of four outcomes: clean, one flipped data bit, one flipped bit inside the stored ECC itself, or damage it cannot repair. When a single data bit is wrong, the block reports the byte offset and the bit to invert. It can optionally invert that bit in an external 256-byte buffer through a byte-wide read-then-write port. When the stored ECC has a single flipped bit, the block hands back the freshly computed code as the repaired stored code.

A check enters on a valid/ready handshake. `chk_ready` is high only while the block is idle, so it accepts one check at a time. The source must hold `chk_valid`, `stored_code` and `calc_code` steady until it sees `chk_ready` high at a rising edge. There is no back-pressure on the result side: `res_valid` is a single-cycle pulse, and the result fields stay unchanged until the next check finishes.

Top module: `nsyn_top`

## Requirements
- R1: Code byte 0 occupies bits [7:0], byte 1 bits [15:8] and byte 2 bits [23:16]. The syndrome bytes s0, s1 and s2 are the XOR of the stored and computed codes byte by byte. An all-zero syndrome gives result code 0 (clean).
- R2: Each accepted check produces exactly one `res_valid` pulse, one cycle wide. The pulse comes on the first rising edge after the accepting edge when no buffer fix-up runs, and on the third edge when one does.
- R3: The result is code 1 (data bit error) exactly when three conditions hold. In s0 and s1, bits 7/6, 5/4, 3/2 and 1/0 each differ. In s2, bits 7/6, 5/4 and 3/2 each differ. Bits 1 and 0 of s2 do not affect this decision.
- R4: For code 1, `fix_addr` bits 7..4 are s0 bits 7, 5, 3, 1, and bits 3..0 are s1 bits 7, 5, 3, 1. `fix_bit` bits 2, 1, 0 are s2 bits 7, 5, 3.
- R5: If R3 does not hold and exactly one syndrome bit is set, the result is code 2 (ECC field error) and `repl_code` equals the computed code.
- R6: Any other nonzero syndrome gives code 3 (uncorrectable). For codes 0, 1 and 3, `repl_code` equals the stored code.
- R7: For code 1, with the fix-up enabled, the block reads byte `fix_addr` once and writes it back once with bit `fix_bit` inverted. The read data is expected on `buf_rdata` one cycle after `buf_rd`. No other byte changes.
- R8: For codes 0, 2 and 3, the buffer port performs no write.
- R9: `chk_ready` is high after reset and low from the accepting edge until the result pulse has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | Check request valid |
| chk_ready | output | 1 | Block idle, request accepted at this edge |
| stored_code | input | 24 | ECC read from the medium |
| calc_code | input | 24 | ECC computed over the data |
| res_valid | output | 1 | One-cycle result strobe |
| res_code | output | 2 | 0 clean, 1 data bit, 2 ECC field, 3 uncorrectable |
| fix_addr | output | 8 | Byte offset of the bad data bit |
| fix_bit | output | 3 | Bit index within that byte |
| repl_code | output | 24 | Code to keep as the stored ECC |
| buf_addr | output | 8 | Buffer byte address |
| buf_rd | output | 1 | Buffer read strobe |
| buf_rdata | input | 8 | Buffer read data, one cycle after buf_rd |
| buf_wr | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |

## Verification
A check without buffer work must produce its result pulse on the first edge after acceptance. A data-bit fix must produce it on the third edge: one edge each for classify, read and write. After every accepted request the bench counts rising edges and samples on the following falling edge. It compares the edge count with 1 or 3, according to the result code its own model predicts. The buffer model counts its write strobes and checks memory after each result, so an absent write or a misplaced write is caught right after the pulse that should have caused it.

// File: rtl/nsyn_pkg.sv
package nsyn_pkg;
  localparam int BYTE_W  = 8;
  localparam int CODE_B  = 3;
  localparam int CODE_W  = BYTE_W * CODE_B;
  localparam int ADDR_W  = 8;
  localparam int BIT_W   = 3;
  localparam int PAIRS   = BYTE_W / 2;

  typedef enum logic [1:0] {
    RES_CLEAN = 2'd0,
    RES_DATA  = 2'd1,
    RES_CODE  = 2'd2,
    RES_BAD   = 2'd3
  } res_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CLASS, ST_RD, ST_WR, ST_DONE
  } st_e;
endpackage

// File: rtl/nsyn_classify.sv
module nsyn_classify
  import nsyn_pkg::*;
(
  input  logic [CODE_W-1:0] stored,
  input  logic [CODE_W-1:0] calc,
  output res_e              kind,
  output logic [ADDR_W-1:0] addr,
  output logic [BIT_W-1:0]  bitpos,
  output logic [CODE_W-1:0] repl
);
  logic [CODE_W-1:0] syn;
  logic [BYTE_W-1:0] s0, s1, s2;
  logic [PAIRS-1:0]  pr0, pr1;
  logic [PAIRS-2:0]  pr2;
  logic [$clog2(CODE_W+1)-1:0] ones;

  assign syn = stored ^ calc;
  assign s0  = syn[BYTE_W-1:0];
  assign s1  = syn[2*BYTE_W-1:BYTE_W];
  assign s2  = syn[3*BYTE_W-1:2*BYTE_W];

  // Pair tests and position bits, one slice per bit pair.
  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    assign pr0[k]          = s0[2*k+1] ^ s0[2*k];
    assign pr1[k]          = s1[2*k+1] ^ s1[2*k];
    assign addr[PAIRS + k] = s0[2*k+1];
    assign addr[k]         = s1[2*k+1];
    if (k > 0) begin : g_hi
      assign pr2[k-1]    = s2[2*k+1] ^ s2[2*k];
      assign bitpos[k-1] = s2[2*k+1];
    end
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < CODE_W; i++) ones = ones + syn[i];
  end

  always_comb begin
    if (syn == '0)                 kind = RES_CLEAN;
    else if (&{pr0, pr1, pr2})     kind = RES_DATA;
    else if (ones == 1)            kind = RES_CODE;
    else                           kind = RES_BAD;
  end

  assign repl = (kind == RES_CODE) ? calc : stored;
endmodule

// File: rtl/nsyn_ctrl.sv
module nsyn_ctrl
  import nsyn_pkg::*;
#(
  parameter bit FIXUP_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_valid,
  output logic              chk_ready,
  input  logic [CODE_W-1:0] stored_in,
  input  logic [CODE_W-1:0] calc_in,
  output logic [CODE_W-1:0] stored_q,
  output logic [CODE_W-1:0] calc_q,
  input  res_e              kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BIT_W-1:0]  bitpos,
  input  logic [CODE_W-1:0] repl,
  output logic              res_valid,
  output logic [1:0]        res_code,
  output logic [ADDR_W-1:0] fix_addr,
  output logic [BIT_W-1:0]  fix_bit,
  output logic [CODE_W-1:0] repl_code,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              buf_rd,
  input  logic [BYTE_W-1:0] buf_rdata,
  output logic              buf_wr,
  output logic [BYTE_W-1:0] buf_wdata
);
  st_e  st, st_nx;
  res_e code_q;
  logic take;

  assign chk_ready = (st == ST_IDLE);
  assign take      = chk_valid && chk_ready;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  if (take) st_nx = ST_CLASS;
      ST_CLASS: st_nx = (FIXUP_EN && kind == RES_DATA) ? ST_RD : ST_DONE;
      ST_RD:    st_nx = ST_WR;
      ST_WR:    st_nx = ST_DONE;
      ST_DONE:  st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      stored_q  <= '0;
      calc_q    <= '0;
      code_q    <= RES_CLEAN;
      fix_addr  <= '0;
      fix_bit   <= '0;
      repl_code <= '0;
    end else begin
      st <= st_nx;
      if (take) begin
        stored_q <= stored_in;
        calc_q   <= calc_in;
      end
      if (st == ST_CLASS) begin
        code_q    <= kind;
        fix_addr  <= addr;
        fix_bit   <= bitpos;
        repl_code <= repl;
      end
    end
  end

  assign res_valid = (st == ST_DONE);
  assign res_code  = code_q;
  assign buf_addr  = fix_addr;

  if (FIXUP_EN) begin : g_fix
    assign buf_rd    = (st == ST_RD);
    assign buf_wr    = (st == ST_WR);
    assign buf_wdata = buf_rdata ^ (BYTE_W'(1) << fix_bit);
  end else begin : g_nofix
    logic unused_rd;
    assign unused_rd = ^buf_rdata;
    assign buf_rd    = 1'b0;
    assign buf_wr    = 1'b0;
    assign buf_wdata = '0;
  end

  // R2: result strobe lasts a single cycle
  a_r2_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R7: each read is followed by its write
  a_r7_rd_then_wr: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd |=> buf_wr);
  // R8: writes happen only for a data-bit result
  a_r8_wr_only_data: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |-> (code_q == RES_DATA));
  // R9: busy once a check is taken
  a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !chk_ready);
  // R5: ECC field repair differs from the stored code in one bit
  a_r5_one_bit_repl: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && code_q == RES_CODE) |-> ($countones(repl_code ^ stored_q) == 1));
endmodule

// File: rtl/nsyn_top.sv
module nsyn_top
  import nsyn_pkg::*;
#(
  parameter bit FIXUP_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chk_valid,
  output logic        chk_ready,
  input  logic [23:0] stored_code,
  input  logic [23:0] calc_code,
  output logic        res_valid,
  output logic [1:0]  res_code,
  output logic [7:0]  fix_addr,
  output logic [2:0]  fix_bit,
  output logic [23:0] repl_code,
  output logic [7:0]  buf_addr,
  output logic        buf_rd,
  input  logic [7:0]  buf_rdata,
  output logic        buf_wr,
  output logic [7:0]  buf_wdata
);
  logic [CODE_W-1:0] stored_q, calc_q, repl;
  res_e              kind;
  logic [ADDR_W-1:0] addr;
  logic [BIT_W-1:0]  bitpos;

  nsyn_classify u_cls (
    .stored (stored_q),
    .calc   (calc_q),
    .kind   (kind),
    .addr   (addr),
    .bitpos (bitpos),
    .repl   (repl)
  );

  nsyn_ctrl #(.FIXUP_EN(FIXUP_EN)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_valid (chk_valid),
    .chk_ready (chk_ready),
    .stored_in (stored_code),
    .calc_in   (calc_code),
    .stored_q  (stored_q),
    .calc_q    (calc_q),
    .kind      (kind),
    .addr      (addr),
    .bitpos    (bitpos),
    .repl      (repl),
    .res_valid (res_valid),
    .res_code  (res_code),
    .fix_addr  (fix_addr),
    .fix_bit   (fix_bit),
    .repl_code (repl_code),
    .buf_addr  (buf_addr),
    .buf_rd    (buf_rd),
    .buf_rdata (buf_rdata),
    .buf_wr    (buf_wr),
    .buf_wdata (buf_wdata)
  );
endmodule

// File: tb/sim_nsyn_top.sv
`timescale 1ns/1ps
module sim_nsyn_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chk_valid = 1'b0;
  logic        chk_ready;
  logic [23:0] stored_code = '0, calc_code = '0;
  logic        res_valid;
  logic [1:0]  res_code;
  logic [7:0]  fix_addr;
  logic [2:0]  fix_bit;
  logic [23:0] repl_code;
  logic [7:0]  buf_addr;
  logic        buf_rd;
  logic [7:0]  buf_rdata;
  logic        buf_wr;
  logic [7:0]  buf_wdata;

  int n_chk = 0, n_fail = 0, n_wr = 0;
  logic [7:0] mem [256];

  always #5 clk = ~clk;

  nsyn_top u0 (.*);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 11);
      buf_rdata <= '0;
    end else begin
      if (buf_rd) buf_rdata <= mem[buf_addr];
      if (buf_wr) begin
        mem[buf_addr] <= buf_wdata;
        n_wr <= n_wr + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Bench model of the classification rules.
  function automatic int model_kind(input logic [23:0] s);
    logic [7:0] d0, d1, d2;
    d0 = s[7:0]; d1 = s[15:8]; d2 = s[23:16];
    if (s == 0) return 0;
    if ((((d0 ^ (d0 >> 1)) & 8'h55) == 8'h55) &&
        (((d1 ^ (d1 >> 1)) & 8'h55) == 8'h55) &&
        (((d2 ^ (d2 >> 1)) & 8'h54) == 8'h54)) return 1;
    if ($countones(s) == 1) return 2;
    return 3;
  endfunction

  function automatic logic [7:0] model_addr(input logic [23:0] s);
    return {s[7], s[5], s[3], s[1], s[15], s[13], s[11], s[9]};
  endfunction

  function automatic logic [2:0] model_bit(input logic [23:0] s);
    return {s[23], s[21], s[19]};
  endfunction

  function automatic logic [23:0] make_data_syn(input logic [7:0] a, input logic [2:0] b,
                                                input logic [1:0] lo);
    logic [23:0] s;
    s = '0;
    for (int k = 0; k < 4; k++) begin
      s[2*k+1]     = a[4+k];  s[2*k]     = ~a[4+k];
      s[8+2*k+1]   = a[k];    s[8+2*k]   = ~a[k];
    end
    for (int k = 1; k < 4; k++) begin
      s[16+2*k+1] = b[k-1];   s[16+2*k] = ~b[k-1];
    end
    s[17:16] = lo;
    return s;
  endfunction

  task automatic run_one(input logic [23:0] st, input logic [23:0] syn, input string tag);
    int ek, edges, wr0;
    logic [7:0] ea, old;
    logic [2:0] eb;
    ek = model_kind(syn); ea = model_addr(syn); eb = model_bit(syn);
    old = mem[ea];
    wr0 = n_wr;
    @(negedge clk);
    stored_code = st; calc_code = st ^ syn; chk_valid = 1'b1;
    @(posedge clk);
    while (!chk_ready) @(posedge clk);
    @(negedge clk);
    chk_valid = 1'b0;
    check(!chk_ready, {"R9 busy ", tag}, chk_ready, 0);
    edges = 0;
    do begin
      @(posedge clk); edges++;
      @(negedge clk);
    end while (!res_valid && edges < 10);
    check(edges == ((ek == 1) ? 3 : 1), {"R2 latency ", tag}, edges, (ek == 1) ? 3 : 1);
    check(res_code == 2'(ek), {(ek == 0) ? "R1" : (ek == 1) ? "R3" : (ek == 2) ? "R5" : "R6",
          " code ", tag}, res_code, ek);
    if (ek == 1) begin
      check(fix_addr == ea, {"R4 addr ", tag}, fix_addr, ea);
      check(fix_bit == eb, {"R4 bit ", tag}, fix_bit, eb);
      check(mem[ea] == (old ^ (8'd1 << eb)), {"R7 byte ", tag}, mem[ea], old ^ (8'd1 << eb));
      check(n_wr - wr0 == 1, {"R7 one write ", tag}, n_wr - wr0, 1);
    end else begin
      check(n_wr == wr0, {"R8 no write ", tag}, n_wr - wr0, 0);
    end
    check(repl_code == ((ek == 2) ? (st ^ syn) : st), {(ek == 2) ? "R5" : "R6", " repl ", tag},
          repl_code, (ek == 2) ? (st ^ syn) : st);
    @(posedge clk); @(negedge clk);
    check(!res_valid && chk_ready, {"R2 pulse end ", tag}, res_valid, 0);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(chk_ready == 1 && res_valid == 0 && buf_rd == 0 && buf_wr == 0,
          "R9 reset state", {chk_ready, res_valid, buf_rd, buf_wr}, 4'b1000);
    rst_n = 1'b1;
    // Directed corners
    run_one(24'h5A3C96, 24'h0, "clean");
    run_one(24'h123456, make_data_syn(8'h00, 3'd0, 2'b00), "addr0 bit0");
    run_one(24'hFFFFFF, make_data_syn(8'hFF, 3'd7, 2'b00), "addr255 bit7");
    run_one(24'h00A0B0, make_data_syn(8'h5C, 3'd2, 2'b11), "s2 low bits ignored");
    run_one(24'h777777, 24'h010000, "ECC bit s2[0]");
    run_one(24'h777777, 24'h000080, "ECC bit s0[7]");
    run_one(24'h777777, 24'h000003, "two bits");
    run_one(24'h777777, make_data_syn(8'h11, 3'd4, 2'b00) ^ 24'h000100, "broken pair");
    // Random mix
    for (int i = 0; i < 60; i++) begin
      logic [23:0] st, syn;
      st = 24'($urandom);
      case ($urandom % 4)
        0: syn = '0;
        1: syn = make_data_syn(8'($urandom), 3'($urandom), 2'($urandom));
        2: syn = 24'd1 << ($urandom % 24);
        default: syn = 24'($urandom);
      endcase
      run_one(st, syn, "random");
    end
    finish_run();
  end
endmodule